// File: doc/BRIEF.md
# SCL Waveform Generator

This block times the two halves of the serial clock for a two-wire bus master. The transfer engine asks for a phase by pulsing a start request together with a phase select (low or high). The block then holds the matching SCL level request for a programmed number of input clock cycles and marks the last cycle of that phase with a one-cycle done pulse. The engine usually starts the next phase in that same cycle, which gives a seamless clock. A one-cycle sampling strobe marks the middle of each phase, so the engine knows when to look at the data line.

The duration of a phase is the phase's own 8-bit divider shifted left by a prescale exponent, plus a fixed offset of four cycles. With equal dividers, the bus clock is the input clock divided by twice that sum. A compatibility parameter sets the offset to three cycles and caps the exponent at five. The block takes a new configuration word only when a low phase starts, so a phase that is already running is never cut short or stretched.

Top module: `scl_wavegen`

## Requirements
- R1: While reset is applied and after it is released, `scl_level` is 1 and `phase_done`, `samp_lo` and `samp_hi` are 0 until the first phase start.
- R2: A low phase (`phase_sel`=0) lasts `cfg_word[7:0]` × 2^`cfg_word[18:16]` + OFFSET cycles. OFFSET is 4, or 3 when LEGACY=1. `phase_done` is high in the last of those cycles, counting the cycle that follows the start edge as the first.
- R3: A high phase (`phase_sel`=1) lasts high divider × 2^exponent + OFFSET cycles. Both the high divider (bits 15:8) and the exponent (bits 18:16) are the ones captured at the most recent low-phase start.
- R4: From the cycle after a start, `scl_level` equals `phase_sel` (0 for low, 1 for high). It keeps that value after the phase ends, until the next start.
- R5: With LEGACY=1, any exponent above 5 acts as 5. With LEGACY=0, exponents 0 to 7 apply unchanged.
- R6: A divider of zero gives a phase of exactly OFFSET cycles.
- R7: The configuration word is captured only at a low-phase start. A change made between that start and the next low-phase start has no effect on the following high phase.
- R8: In a high phase, `samp_hi` pulses once, in the cycle at elapsed index floor(L/2), where the first cycle has index 0 and L is the phase length. `samp_lo` does the same in a low phase. The strobe of the other phase stays 0.
- R9: A start that arrives while a phase is running abandons that phase and begins the new one, with full length, from that edge.
- R10: `phase_done` pulses exactly once per phase, is never high on two consecutive cycles, and stays 0 while no phase is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 19 | Waveform config: low divider [7:0], high divider [15:8], exponent [18:16] |
| phase_start | input | 1 | One-cycle request to begin a phase |
| phase_sel | input | 1 | Phase to begin: 0 low, 1 high |
| phase_done | output | 1 | High in the last cycle of the running phase |
| scl_level | output | 1 | Requested SCL level |
| samp_lo | output | 1 | Mid-point strobe of a low phase |
| samp_hi | output | 1 | Mid-point strobe of a high phase |

## Verification
A wrong down-counter or a wrong length calculation moves `phase_done` and the mid-point strobe by a whole number of cycles, and this shows within the phase in which it happens. A shadow register that loads at the wrong moment leaves the current phase alone. It shows only in the next high phase, which then has the length of the other configuration word. The bench therefore changes the word between the low and high phases. A dropped saturation shows as a legacy phase up to four times too long, so the legacy and default instances run side by side on the same stimulus.

// File: rtl/scl_wave_pkg.sv
// Shared types for the SCL waveform generator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package scl_wave_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/scl_cfg_shadow.sv
// Holds the copy of the waveform word that high phases use.
// Assumes: load is asserted only on a low-phase start edge.
module scl_cfg_shadow #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] hi_div_in,
    input  logic [EXP_W-1:0] exp_in,
    output logic [DIV_W-1:0] hi_div_q,
    output logic [EXP_W-1:0] exp_q
);
    // Capture the high divider and exponent at each low-phase start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_div_q <= '0;
            exp_q    <= '0;
        end else if (load) begin
            hi_div_q <= hi_div_in;
            exp_q    <= exp_in;
        end
    end
endmodule

// File: rtl/scl_phase_len.sv
// Works out the phase length (minus one) and the mid-point count value
// from a divider and a prescale exponent.
// Assumes: CNT_W holds the largest divider shifted by the largest exponent,
// plus the offset.
module scl_phase_len #(
    parameter int DIV_W  = 8,
    parameter int EXP_W  = 3,
    parameter bit LEGACY = 1'b0,
    parameter int CNT_W  = DIV_W + (1 << EXP_W)
) (
    input  logic [DIV_W-1:0] div,
    input  logic [EXP_W-1:0] expo,
    output logic [CNT_W-1:0] len_m1,
    output logic [CNT_W-1:0] mid_cnt
);
    localparam int OFFSET  = LEGACY ? 3 : 4;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam int EXP_MAX = LEGACY ? ((EXP_TOP < 5) ? EXP_TOP : 5) : EXP_TOP;
    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);

    logic [EXP_W-1:0] exp_eff;
    logic [CNT_W-1:0] len;

    // Limit the exponent only when the variant caps it below the field range
    generate
        if (EXP_MAX < EXP_TOP) begin : g_sat
            always_comb exp_eff = (expo > EXP_CAP) ? EXP_CAP : expo;
        end else begin : g_full
            always_comb exp_eff = expo;
        end
    endgenerate

    // Compute the length, the terminal count and the mid-point count
    always_comb begin
        len     = (CNT_W'(div) << exp_eff) + CNT_W'(OFFSET);
        len_m1  = len - CNT_W'(1);
        mid_cnt = len_m1 - (len >> 1);
    end
endmodule

// File: rtl/scl_phase_timer.sv
// Counts one SCL phase down. Drives the level request, the done pulse in
// the last cycle and the mid-point strobes.
// Assumes: a length of at least three cycles, so the mid-point and the end
// never fall in the same cycle.
module scl_phase_timer
    import scl_wave_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  scl_phase_e       sel,
    input  logic [CNT_W-1:0] len_m1,
    input  logic [CNT_W-1:0] mid_cnt,
    output logic             done,
    output logic             level,
    output logic             samp_lo,
    output logic             samp_hi
);
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mid_q;
    scl_phase_e       sel_q;
    logic             at_mid;

    // Load a phase on start, count it down, and keep the level request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            mid_q  <= '0;
            sel_q  <= PH_LOW;
            level  <= 1'b1;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= len_m1;
            mid_q  <= mid_cnt;
            sel_q  <= sel;
            level  <= (sel == PH_HIGH);
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - CNT_W'(1);
        end
    end

    // Decode the end of the phase and the mid-point
    always_comb begin
        done    = active && (cnt == '0);
        at_mid  = active && (cnt == mid_q);
        samp_hi = at_mid && (sel_q == PH_HIGH);
        samp_lo = at_mid && (sel_q == PH_LOW);
    end
endmodule

// File: rtl/scl_wavegen.sv
// SCL waveform generator top. Splits the config word into its fields, uses
// the live word for low phases and the shadow copy for high phases, and
// times the requested phase.
// Assumes: the engine pulses phase_start for one cycle per phase.
module scl_wavegen
    import scl_wave_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int EXP_W  = 3,
    parameter bit LEGACY = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*DIV_W+EXP_W-1:0] cfg_word,
    input  logic                     phase_start,
    input  logic                     phase_sel,
    output logic                     phase_done,
    output logic                     scl_level,
    output logic                     samp_lo,
    output logic                     samp_hi
);
    localparam int CNT_W = DIV_W + (1 << EXP_W);

    logic [DIV_W-1:0] cfg_lo, cfg_hi, sh_hi, div_pick;
    logic [EXP_W-1:0] cfg_exp, sh_exp, exp_pick;
    logic [CNT_W-1:0] len_m1, mid_cnt;
    scl_phase_e       sel_e;
    logic             low_start;

    // Split the word and pick the source for the requested phase
    always_comb begin
        cfg_lo    = cfg_word[DIV_W-1:0];
        cfg_hi    = cfg_word[2*DIV_W-1:DIV_W];
        cfg_exp   = cfg_word[2*DIV_W+EXP_W-1:2*DIV_W];
        sel_e     = scl_phase_e'(phase_sel);
        low_start = phase_start && (sel_e == PH_LOW);
        div_pick  = (sel_e == PH_LOW) ? cfg_lo  : sh_hi;
        exp_pick  = (sel_e == PH_LOW) ? cfg_exp : sh_exp;
    end

    scl_cfg_shadow #(.DIV_W(DIV_W), .EXP_W(EXP_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (low_start),
        .hi_div_in (cfg_hi),
        .exp_in    (cfg_exp),
        .hi_div_q  (sh_hi),
        .exp_q     (sh_exp)
    );

    scl_phase_len #(.DIV_W(DIV_W), .EXP_W(EXP_W), .LEGACY(LEGACY), .CNT_W(CNT_W)) u_len (
        .div     (div_pick),
        .expo    (exp_pick),
        .len_m1  (len_m1),
        .mid_cnt (mid_cnt)
    );

    scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (phase_start),
        .sel     (sel_e),
        .len_m1  (len_m1),
        .mid_cnt (mid_cnt),
        .done    (phase_done),
        .level   (scl_level),
        .samp_lo (samp_lo),
        .samp_hi (samp_hi)
    );
endmodule

// File: rtl/scl_wavegen_chk.sv
// Port-level checker for scl_wavegen, attached with bind.
// Assumes: synchronous active-low reset on the same clock.
module scl_wavegen_chk #(
    parameter bit LEGACY = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic phase_start,
    input logic phase_sel,
    input logic phase_done,
    input logic scl_level,
    input logic samp_lo,
    input logic samp_hi
);
    localparam int OFFSET = LEGACY ? 3 : 4;

    logic [15:0] since_start;
    logic        seen_start;

    // Track cycles since the last start, saturating at the counter limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_start <= '0;
            seen_start  <= 1'b0;
        end else if (phase_start) begin
            since_start <= '0;
            seen_start  <= 1'b1;
        end else if (since_start != 16'hFFFF) begin
            since_start <= since_start + 16'd1;
        end
    end

    // R4
    level_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_start |=> (scl_level == $past(phase_sel)));

    // R8
    strobe_hi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_hi |-> (scl_level && !samp_lo && !phase_done));

    // R8
    strobe_lo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_lo |-> (!scl_level && !phase_done));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> !phase_done);

    // R10
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |-> seen_start);

    // R6
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |-> (since_start >= 16'(OFFSET - 1)));
endmodule

bind scl_wavegen scl_wavegen_chk #(.LEGACY(LEGACY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_start (phase_start),
    .phase_sel   (phase_sel),
    .phase_done  (phase_done),
    .scl_level   (scl_level),
    .samp_lo     (samp_lo),
    .samp_hi     (samp_hi)
);

// File: tb/sim_scl_wavegen.sv
module sim_scl_wavegen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] cfg_word = '0;
    logic        phase_start = 1'b0;
    logic        phase_sel = 1'b0;
    logic        done0, lvl0, slo0, shi0;
    logic        done1, lvl1, slo1, shi1;
    logic [18:0] sh_cfg = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    int unsigned seed_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_wavegen #(.LEGACY(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .phase_start(phase_start),
        .phase_sel(phase_sel), .phase_done(done0), .scl_level(lvl0),
        .samp_lo(slo0), .samp_hi(shi0));

    scl_wavegen #(.LEGACY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .phase_start(phase_start),
        .phase_sel(phase_sel), .phase_done(done1), .scl_level(lvl1),
        .samp_lo(slo1), .samp_hi(shi1));

    function automatic int exp_len(input logic [7:0] dv, input logic [2:0] e, input bit legacy);
        int ee = int'(e);
        if (legacy && ee > 5) ee = 5;
        return int'(dv) * (1 << ee) + (legacy ? 3 : 4);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    // Start one phase and check both instances over its whole length
    task automatic measure(input logic sel, input string tag);
        int l0, l1, mx;
        int d0k = -1, d1k = -1, dn0 = 0, dn1 = 0;
        int s0k = -1, s1k = -1, sn0 = 0, sn1 = 0, bad0 = 0, bad1 = 0;
        logic v0, v1;
        if (sel == 1'b0) begin
            sh_cfg = cfg_word;
            l0 = exp_len(cfg_word[7:0], cfg_word[18:16], 1'b0);
            l1 = exp_len(cfg_word[7:0], cfg_word[18:16], 1'b1);
        end else begin
            l0 = exp_len(sh_cfg[15:8], sh_cfg[18:16], 1'b0);
            l1 = exp_len(sh_cfg[15:8], sh_cfg[18:16], 1'b1);
        end
        mx = (l0 > l1) ? l0 : l1;
        @(negedge clk);
        phase_start = 1'b1;
        phase_sel   = sel;
        @(negedge clk);
        phase_start = 1'b0;
        v0 = lvl0;
        v1 = lvl1;
        for (int k = 0; k <= mx; k++) begin
            if (done0) begin dn0++; if (d0k < 0) d0k = k; end
            if (done1) begin dn1++; if (d1k < 0) d1k = k; end
            if (sel ? shi0 : slo0) begin sn0++; if (s0k < 0) s0k = k; end
            if (sel ? shi1 : slo1) begin sn1++; if (s1k < 0) s1k = k; end
            if (sel ? slo0 : shi0) bad0++;
            if (sel ? slo1 : shi1) bad1++;
            if (k < mx) @(negedge clk);
        end
        chk(d0k == l0 - 1 && dn0 == 1, tag, d0k, l0 - 1);
        chk(d1k == l1 - 1 && dn1 == 1, tag, d1k, l1 - 1);
        chk(s0k == l0 / 2 && sn0 == 1 && bad0 == 0, "R8", s0k, l0 / 2);
        chk(s1k == l1 / 2 && sn1 == 1 && bad1 == 0, "R8", s1k, l1 / 2);
        chk(v0 == sel && v1 == sel, "R4", int'(v0), int'(sel));
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: outputs while held in reset
        chk(lvl0 && lvl1 && !done0 && !done1, "R1", int'(lvl0), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!slo0 && !shi0 && !slo1 && !shi1, "R1", int'(slo0 | shi0), 0);
        chk(lvl0 && !done0 && !done1, "R1", int'(done0), 0);

        // R2 / R3: basic low and high phases
        cfg_word = {3'd0, 8'd2, 8'd1};
        measure(1'b0, "R2");
        measure(1'b1, "R3");
        cfg_word = {3'd2, 8'd5, 8'd3};
        measure(1'b0, "R2");
        measure(1'b1, "R3");

        // R6: zero dividers give the bare offset
        cfg_word = '0;
        measure(1'b0, "R6");
        measure(1'b1, "R6");

        // R5: exponent above the legacy cap
        cfg_word = {3'd7, 8'd1, 8'd3};
        measure(1'b0, "R5");
        measure(1'b1, "R5");
        cfg_word = {3'd6, 8'd2, 8'd0};
        measure(1'b0, "R5");
        measure(1'b1, "R5");

        // R7: a word written after the low start is ignored by the high phase
        cfg_word = {3'd1, 8'd4, 8'd2};
        measure(1'b0, "R7");
        cfg_word = {3'd2, 8'd9, 8'd7};
        measure(1'b1, "R7");
        measure(1'b0, "R7");
        measure(1'b1, "R7");

        // R9: restart during a long low phase
        cfg_word = {3'd3, 8'd5, 8'd50};
        @(negedge clk);
        phase_start = 1'b1;
        phase_sel   = 1'b0;
        sh_cfg      = cfg_word;
        repeat (6) @(negedge clk) phase_start = 1'b0;
        measure(1'b1, "R9");

        // R10 / R4: idle after a low phase, no done and the level held
        measure(1'b0, "R10");
        begin
            int extra = 0;
            int lowcnt = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (done0 || done1) extra++;
                if (!lvl0 && !lvl1) lowcnt++;
            end
            chk(extra == 0, "R10", extra, 0);
            chk(lowcnt == 12, "R4", lowcnt, 12);
        end

        // R2: largest length
        cfg_word = {3'd7, 8'd255, 8'd255};
        measure(1'b0, "R2");

        // Random mix of words with back-to-back phases
        for (int n = 0; n < 30; n++) begin
            cfg_word = {3'($urandom % 5), 8'($urandom % 16), 8'($urandom % 16)};
            measure(1'b0, "R2");
            if (($urandom % 2) == 1)
                cfg_word = {3'($urandom % 5), 8'($urandom % 16), 8'($urandom % 16)};
            measure(1'b1, "R3");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule